// File: doc/BRIEF.md
# Synchronous Exception Prioritizer and Trap Capture

This unit sits beside the commit stage of a small in-order pipeline. Each cycle the commit stage presents one instruction together with the exception flags raised for it by fetch, decode and the memory access. When the instruction is valid and at least one flag is set, the unit picks the single exception with the highest fixed priority. It encodes that exception's cause code and chooses the trap value for that cause. In the same cycle it asserts a squash of all younger in-flight work and a fetch redirect to the trap vector base. Only Direct mode is supported, so the two low bits of the base are forced to zero.

On the clock edge that ends a trap cycle, the unit records four things: the cause, the trap value, the faulting instruction's own PC and the privilege mode that was current. These records are held unchanged until the next trap is taken. Interrupts, vectored dispatch and privilege switching are handled elsewhere.

The flags arrive on one 10-bit bus. The bit position is the priority rank, and a lower index wins.

Top module: `exc_trap_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `cause_q_o`, `tval_q_o`, `epc_q_o` and `trap_priv_q_o` read zero. `trap_taken_o` is low whenever `commit_valid_i` is low.
- R2: The fetch-side flags rank first, in this order. Bit 0 is a fetch page fault (cause 12). Bit 1 is a fetch access fault (cause 1). Bit 2 is an illegal instruction (cause 2). Bit 3 is a misaligned fetch target (cause 0). Any of these wins over every higher-numbered bit.
- R3: Bit 4 is an environment call. Its cause is 8 when `cur_priv_i` is 2'b00 (user) and 9 when it is 2'b01 (supervisor). It is 11 for 2'b11 (machine) and also for the unused value 2'b10.
- R4: Below the environment call the order is as follows. Bit 5 is a breakpoint instruction (cause 3). Bit 6 is a data address breakpoint (cause 3). Bit 7 is a misaligned data access. Bit 8 is a data page fault. Bit 9 is a data access fault.
- R5: Data exceptions take their cause from `mem_is_store_i`, which is 0 for a load and 1 for a store or atomic operation. Misaligned gives 4 or 6, page fault gives 13 or 15, and access fault gives 5 or 7.
- R6: The recorded trap value depends on the winning bit. Bits 0, 1 and 3 give `fetch_vaddr_i`. Bits 6 to 9 give `mem_vaddr_i`. Bits 2, 4 and 5 give zero.
- R7: On a trap, `epc_q_o` takes the `commit_pc_i` of the faulting instruction and `trap_priv_q_o` takes `cur_priv_i`, both on the next clock edge.
- R8: In a trap cycle, `squash_o` is high and `redirect_pc_o` equals `tvec_base_i` with bits [1:0] cleared, in the same cycle with no register delay.
- R9: When `commit_valid_i` is low or no flag is set, no trap is taken. All recorded registers then hold their previous contents.
- R10: A recorded cause is always one of 0 to 9, 11, 12, 13 or 15. Reserved and custom values are never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_valid_i | input | 1 | A valid instruction is at commit |
| commit_pc_i | input | XLEN | PC of the committing instruction |
| cur_priv_i | input | 2 | Current privilege mode (00 U, 01 S, 11 M) |
| exc_flags_i | input | 10 | Exception flags; the bit index is the priority rank (R2, R4) |
| mem_is_store_i | input | 1 | Data access is a store or atomic operation |
| fetch_vaddr_i | input | XLEN | Virtual address of the faulting fetch |
| mem_vaddr_i | input | XLEN | Virtual address of the data access |
| tvec_base_i | input | XLEN | Trap vector register contents |
| trap_taken_o | output | 1 | A trap is taken this cycle |
| squash_o | output | 1 | Flush younger instructions |
| redirect_pc_o | output | XLEN | Next fetch address on a trap |
| cause_q_o | output | XLEN | Recorded cause code |
| tval_q_o | output | XLEN | Recorded trap value |
| epc_q_o | output | XLEN | Recorded faulting PC |
| trap_priv_q_o | output | 2 | Privilege mode recorded at the trap |

## Verification
Within one trap cycle the unit resolves priority and selects the trap value, and these two can disagree when a fetch-side fault and a data-side fault are raised together. The winner's cause can then point at one address source while a losing flag points at the other. The bench provokes this with table rows that mix fetch and data flags, and with random flag words that often set several bits at once. Each result is judged against a reference model in the bench: the lowest set bit fixes the cause, and the model also picks the trap value source. The fetch and data addresses are always driven with distinct values, so a wrong pick is visible.

// File: rtl/exc_trap_pkg.sv
// Shared constants for the exception prioritizer.
// Assumes the flag bus is ordered by priority rank, with bit 0 highest.
package exc_trap_pkg;

    localparam int NUM_EXC = 10;
    localparam int IDX_W   = $clog2(NUM_EXC);
    localparam int CAUSE_W = 6;

    // Flag positions (bit index is the priority rank)
    localparam int unsigned FL_FETCH_PF  = 0;
    localparam int unsigned FL_FETCH_AF  = 1;
    localparam int unsigned FL_ILLEGAL   = 2;
    localparam int unsigned FL_FETCH_MIS = 3;
    localparam int unsigned FL_ENV_CALL  = 4;
    localparam int unsigned FL_BRK_INSN  = 5;
    localparam int unsigned FL_DATA_BKPT = 6;
    localparam int unsigned FL_DATA_MIS  = 7;
    localparam int unsigned FL_DATA_PF   = 8;
    localparam int unsigned FL_DATA_AF   = 9;

    // Architectural cause codes
    localparam logic [CAUSE_W-1:0] C_FETCH_MIS = 6'd0;
    localparam logic [CAUSE_W-1:0] C_FETCH_AF  = 6'd1;
    localparam logic [CAUSE_W-1:0] C_ILLEGAL   = 6'd2;
    localparam logic [CAUSE_W-1:0] C_BREAK     = 6'd3;
    localparam logic [CAUSE_W-1:0] C_LD_MIS    = 6'd4;
    localparam logic [CAUSE_W-1:0] C_LD_AF     = 6'd5;
    localparam logic [CAUSE_W-1:0] C_ST_MIS    = 6'd6;
    localparam logic [CAUSE_W-1:0] C_ST_AF     = 6'd7;
    localparam logic [CAUSE_W-1:0] C_ECALL_U   = 6'd8;
    localparam logic [CAUSE_W-1:0] C_ECALL_S   = 6'd9;
    localparam logic [CAUSE_W-1:0] C_ECALL_M   = 6'd11;
    localparam logic [CAUSE_W-1:0] C_FETCH_PF  = 6'd12;
    localparam logic [CAUSE_W-1:0] C_LD_PF     = 6'd13;
    localparam logic [CAUSE_W-1:0] C_ST_PF     = 6'd15;

    // Where the trap value comes from
    typedef enum logic [1:0] {
        TV_ZERO  = 2'd0,
        TV_FETCH = 2'd1,
        TV_DATA  = 2'd2
    } tval_src_e;

endpackage

// File: rtl/exc_prio_sel.sv
// Fixed-priority picker: finds the lowest set flag index.
// Assumes flag index equals priority rank (0 = highest).
module exc_prio_sel
    import exc_trap_pkg::*;
(
    input  logic [NUM_EXC-1:0] flags_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the lowest-ranked bit so the highest-ranked set bit is written last
    always_comb begin
        idx_o = '0;
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (flags_i[i]) idx_o = i[IDX_W-1:0];
        end
    end

    // Any flag raised at all
    assign any_o = |flags_i;

endmodule

// File: rtl/exc_cause_enc.sv
// Maps the winning flag index to a cause code and a trap value source.
// Assumes privilege encoding 00 user, 01 supervisor, 10/11 machine.
module exc_cause_enc
    import exc_trap_pkg::*;
(
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [1:0]         priv_i,
    input  logic               is_store_i,
    output logic [CAUSE_W-1:0] cause_o,
    output tval_src_e          src_o
);

    // Cause code per winner, split by access kind and privilege
    always_comb begin
        cause_o = C_FETCH_MIS;
        src_o   = TV_ZERO;
        case (32'(idx_i))
            FL_FETCH_PF:  begin cause_o = C_FETCH_PF;  src_o = TV_FETCH; end
            FL_FETCH_AF:  begin cause_o = C_FETCH_AF;  src_o = TV_FETCH; end
            FL_ILLEGAL:   begin cause_o = C_ILLEGAL;   src_o = TV_ZERO;  end
            FL_FETCH_MIS: begin cause_o = C_FETCH_MIS; src_o = TV_FETCH; end
            FL_ENV_CALL: begin
                src_o = TV_ZERO;
                case (priv_i)
                    2'b00:   cause_o = C_ECALL_U;
                    2'b01:   cause_o = C_ECALL_S;
                    default: cause_o = C_ECALL_M;
                endcase
            end
            FL_BRK_INSN:  begin cause_o = C_BREAK; src_o = TV_ZERO; end
            FL_DATA_BKPT: begin cause_o = C_BREAK; src_o = TV_DATA; end
            FL_DATA_MIS: begin
                cause_o = is_store_i ? C_ST_MIS : C_LD_MIS;
                src_o   = TV_DATA;
            end
            FL_DATA_PF: begin
                cause_o = is_store_i ? C_ST_PF : C_LD_PF;
                src_o   = TV_DATA;
            end
            FL_DATA_AF: begin
                cause_o = is_store_i ? C_ST_AF : C_LD_AF;
                src_o   = TV_DATA;
            end
            default: begin cause_o = C_FETCH_MIS; src_o = TV_ZERO; end
        endcase
    end

endmodule

// File: rtl/trap_capture_regs.sv
// Holds cause, trap value, faulting PC and privilege after a trap.
// Assumes take_i is a single-cycle strobe; registers hold otherwise.
module trap_capture_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    tval_i,
    input  logic [XLEN-1:0]    epc_i,
    input  logic [1:0]         priv_i,
    output logic [XLEN-1:0]    cause_q_o,
    output logic [XLEN-1:0]    tval_q_o,
    output logic [XLEN-1:0]    epc_q_o,
    output logic [1:0]         priv_q_o
);

    // Capture the trap record on a taken trap, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q_o <= '0;
            tval_q_o  <= '0;
            epc_q_o   <= '0;
            priv_q_o  <= '0;
        end else if (take_i) begin
            cause_q_o <= XLEN'(cause_i);
            tval_q_o  <= tval_i;
            epc_q_o   <= epc_i;
            priv_q_o  <= priv_i;
        end
    end

endmodule

// File: rtl/exc_trap_unit.sv
// Top of the synchronous exception prioritizer and trap capture.
// Resolves one exception per cycle at commit, squashes younger work,
// redirects fetch to the Direct-mode vector base and records the trap.
module exc_trap_unit
    import exc_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_valid_i,
    input  logic [XLEN-1:0]    commit_pc_i,
    input  logic [1:0]         cur_priv_i,
    input  logic [NUM_EXC-1:0] exc_flags_i,
    input  logic               mem_is_store_i,
    input  logic [XLEN-1:0]    fetch_vaddr_i,
    input  logic [XLEN-1:0]    mem_vaddr_i,
    input  logic [XLEN-1:0]    tvec_base_i,
    output logic               trap_taken_o,
    output logic               squash_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [XLEN-1:0]    cause_q_o,
    output logic [XLEN-1:0]    tval_q_o,
    output logic [XLEN-1:0]    epc_q_o,
    output logic [1:0]         trap_priv_q_o
);

    logic               any_exc;
    logic [IDX_W-1:0]   win_idx;
    logic [CAUSE_W-1:0] win_cause;
    tval_src_e          win_src;
    logic [XLEN-1:0]    win_tval;

    exc_prio_sel u_sel (
        .flags_i (exc_flags_i),
        .any_o   (any_exc),
        .idx_o   (win_idx)
    );

    exc_cause_enc u_enc (
        .idx_i      (win_idx),
        .priv_i     (cur_priv_i),
        .is_store_i (mem_is_store_i),
        .cause_o    (win_cause),
        .src_o      (win_src)
    );

    // Pick the trap value from the source the winning cause names
    always_comb begin
        case (win_src)
            TV_FETCH: win_tval = fetch_vaddr_i;
            TV_DATA:  win_tval = mem_vaddr_i;
            default:  win_tval = '0;
        endcase
    end

    // Trap strobe, flush and Direct-mode redirect in the same cycle
    assign trap_taken_o  = commit_valid_i & any_exc;
    assign squash_o      = trap_taken_o;
    assign redirect_pc_o = {tvec_base_i[XLEN-1:2], 2'b00};

    trap_capture_regs #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (trap_taken_o),
        .cause_i   (win_cause),
        .tval_i    (win_tval),
        .epc_i     (commit_pc_i),
        .priv_i    (cur_priv_i),
        .cause_q_o (cause_q_o),
        .tval_q_o  (tval_q_o),
        .epc_q_o   (epc_q_o),
        .priv_q_o  (trap_priv_q_o)
    );

endmodule

// File: rtl/exc_trap_unit_chk.sv
// Property checker for exc_trap_unit, attached with bind.
// Observes ports only; assumes synchronous active-low reset.
module exc_trap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            commit_valid_i,
    input logic [XLEN-1:0] commit_pc_i,
    input logic [1:0]      cur_priv_i,
    input logic [9:0]      exc_flags_i,
    input logic            trap_taken_o,
    input logic            squash_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic [XLEN-1:0] cause_q_o,
    input logic [XLEN-1:0] tval_q_o,
    input logic [XLEN-1:0] epc_q_o,
    input logic [1:0]      trap_priv_q_o
);

    // R1: no trap without a valid commit
    p_no_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_valid_i |-> !trap_taken_o);

    // R9: no flags means no trap
    p_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_flags_i == '0) |-> !trap_taken_o);

    // R9: records hold when no trap is taken
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_taken_o |=> ($stable(cause_q_o) && $stable(tval_q_o)
                           && $stable(epc_q_o) && $stable(trap_priv_q_o)));

    // R7: faulting PC and mode captured
    p_epc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |=> (epc_q_o == $past(commit_pc_i)
                          && trap_priv_q_o == $past(cur_priv_i)));

    // R8: squash and aligned redirect in the trap cycle
    p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |-> (squash_o && redirect_pc_o[1:0] == 2'b00));

    // R10: only legal standard cause codes are recorded
    p_legal_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |=> (cause_q_o <= 32'd9 || cause_q_o == 32'd11
                          || cause_q_o == 32'd12 || cause_q_o == 32'd13
                          || cause_q_o == 32'd15));

    // R3: a lone environment call records one of the call causes
    p_ecall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken_o && exc_flags_i[3:0] == 4'b0 && exc_flags_i[4])
        |=> (cause_q_o == 32'd8 || cause_q_o == 32'd9 || cause_q_o == 32'd11));

    // R6: illegal instruction and call causes carry zero trap value
    p_tval_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |=> (!(cause_q_o == 32'd2 || cause_q_o == 32'd8
                            || cause_q_o == 32'd9 || cause_q_o == 32'd11)
                          || tval_q_o == '0));

endmodule

bind exc_trap_unit exc_trap_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .commit_valid_i (commit_valid_i),
    .commit_pc_i    (commit_pc_i),
    .cur_priv_i     (cur_priv_i),
    .exc_flags_i    (exc_flags_i),
    .trap_taken_o   (trap_taken_o),
    .squash_o       (squash_o),
    .redirect_pc_o  (redirect_pc_o),
    .cause_q_o      (cause_q_o),
    .tval_q_o       (tval_q_o),
    .epc_q_o        (epc_q_o),
    .trap_priv_q_o  (trap_priv_q_o)
);

// File: tb/exc_trap_unit_tb_top.sv
`timescale 1ns/1ps
module exc_trap_unit_tb_top;

    localparam int XLEN = 32;
    localparam logic [31:0] TVEC = 32'h8000_0103;
    localparam logic [31:0] TVEC_EXP = 32'h8000_0100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            commit_valid_i = 1'b0;
    logic [31:0]     commit_pc_i = '0;
    logic [1:0]      cur_priv_i = '0;
    logic [9:0]      exc_flags_i = '0;
    logic            mem_is_store_i = 1'b0;
    logic [31:0]     fetch_vaddr_i = '0;
    logic [31:0]     mem_vaddr_i = '0;
    logic [31:0]     tvec_base_i = TVEC;
    logic            trap_taken_o, squash_o;
    logic [31:0]     redirect_pc_o, cause_q_o, tval_q_o, epc_q_o;
    logic [1:0]      trap_priv_q_o;

    int n_total = 0;
    int n_bad   = 0;

    logic [31:0] e_cause = '0, e_tval = '0, e_epc = '0;
    logic [1:0]  e_priv = '0;

    always #5 clk = ~clk;

    exc_trap_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .commit_valid_i(commit_valid_i),
        .commit_pc_i(commit_pc_i), .cur_priv_i(cur_priv_i),
        .exc_flags_i(exc_flags_i), .mem_is_store_i(mem_is_store_i),
        .fetch_vaddr_i(fetch_vaddr_i), .mem_vaddr_i(mem_vaddr_i),
        .tvec_base_i(tvec_base_i), .trap_taken_o(trap_taken_o),
        .squash_o(squash_o), .redirect_pc_o(redirect_pc_o),
        .cause_q_o(cause_q_o), .tval_q_o(tval_q_o), .epc_q_o(epc_q_o),
        .trap_priv_q_o(trap_priv_q_o)
    );

    // Directed table: {flags[9:0], priv[1:0], store, cause[5:0]}
    localparam int NVEC = 17;
    localparam logic [18:0] VEC [NVEC] = '{
        {10'h3FF, 2'd0, 1'b0, 6'd12},   // R2 fetch page fault wins all
        {10'h00E, 2'd0, 1'b0, 6'd1},    // R2
        {10'h00C, 2'd3, 1'b1, 6'd2},    // R2
        {10'h308, 2'd0, 1'b0, 6'd0},    // R2 fetch misaligned over data faults
        {10'h010, 2'd0, 1'b0, 6'd8},    // R3 user
        {10'h030, 2'd1, 1'b0, 6'd9},    // R3 supervisor, over breakpoint
        {10'h010, 2'd3, 1'b1, 6'd11},   // R3 machine
        {10'h010, 2'd2, 1'b0, 6'd11},   // R3 unused mode value
        {10'h020, 2'd3, 1'b0, 6'd3},    // R4 breakpoint instruction
        {10'h260, 2'd0, 1'b0, 6'd3},    // R4 breakpoint over data faults
        {10'h0C0, 2'd0, 1'b1, 6'd3},    // R4 data breakpoint over misaligned
        {10'h380, 2'd0, 1'b0, 6'd4},    // R5 load misaligned
        {10'h380, 2'd0, 1'b1, 6'd6},    // R5 store misaligned
        {10'h300, 2'd3, 1'b0, 6'd13},   // R5 load page fault
        {10'h300, 2'd3, 1'b1, 6'd15},   // R5 store page fault
        {10'h200, 2'd1, 1'b0, 6'd5},    // R5 load access fault
        {10'h200, 2'd1, 1'b1, 6'd7}     // R5 store access fault
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: lowest set bit decides the cause
    function automatic logic [31:0] ref_cause(input logic [9:0] f, input logic [1:0] p, input logic st);
        for (int i = 0; i < 10; i++) begin
            if (f[i]) begin
                case (i)
                    0: return 32'd12;
                    1: return 32'd1;
                    2: return 32'd2;
                    3: return 32'd0;
                    4: return (p == 2'b00) ? 32'd8 : (p == 2'b01) ? 32'd9 : 32'd11;
                    5: return 32'd3;
                    6: return 32'd3;
                    7: return st ? 32'd6 : 32'd4;
                    8: return st ? 32'd15 : 32'd13;
                    default: return st ? 32'd7 : 32'd5;
                endcase
            end
        end
        return 32'd0;
    endfunction

    // Reference: trap value source per winning bit (R6)
    function automatic logic [31:0] ref_tval(input logic [9:0] f, input logic [31:0] fva, input logic [31:0] mva);
        for (int i = 0; i < 10; i++) begin
            if (f[i]) begin
                if (i == 0 || i == 1 || i == 3) return fva;
                if (i >= 6) return mva;
                return 32'd0;
            end
        end
        return 32'd0;
    endfunction

    // Drive one commit at a falling edge, check combinational then registered results
    task automatic apply(input logic v, input logic [9:0] f, input logic [1:0] p,
                         input logic st, input logic [31:0] pc, input logic [31:0] fva,
                         input logic [31:0] mva, input logic [31:0] exp_cause_in, input bit use_in);
        logic take;
        logic [31:0] ec;
        commit_valid_i = v; exc_flags_i = f; cur_priv_i = p; mem_is_store_i = st;
        commit_pc_i = pc; fetch_vaddr_i = fva; mem_vaddr_i = mva;
        take = v && (f != '0);
        ec = use_in ? exp_cause_in : ref_cause(f, p, st);
        #1;
        check(take ? "R8 trap_taken" : "R9 trap_taken", {31'd0, trap_taken_o}, {31'd0, take});
        check("R8 squash", {31'd0, squash_o}, {31'd0, take});
        if (take) check("R8 redirect", redirect_pc_o, TVEC_EXP);
        if (take) begin
            e_cause = ec; e_tval = ref_tval(f, fva, mva); e_epc = pc; e_priv = p;
        end
        @(negedge clk);
        check(take ? "R2-R5 cause" : "R9 cause hold", cause_q_o, e_cause);
        check(take ? "R6 tval" : "R9 tval hold", tval_q_o, e_tval);
        check(take ? "R7 epc" : "R9 epc hold", epc_q_o, e_epc);
        check("R7 priv", {30'd0, trap_priv_q_o}, {30'd0, e_priv});
        if (take) check("R10 legal cause", {31'd0, (cause_q_o <= 9 || cause_q_o == 11 ||
              cause_q_o == 12 || cause_q_o == 13 || cause_q_o == 15)}, 32'd1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cause reset", cause_q_o, 32'd0);
        check("R1 tval reset", tval_q_o, 32'd0);
        check("R1 epc reset", epc_q_o, 32'd0);
        check("R1 trap_taken idle", {31'd0, trap_taken_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 epc after release", epc_q_o, 32'd0);

        // Directed table
        for (int k = 0; k < NVEC; k++) begin
            apply(1'b1, VEC[k][18:9], VEC[k][8:7], VEC[k][6],
                  32'h0000_1000 + 32'(k) * 4, 32'hF000_0000 + 32'(k),
                  32'hD000_0000 + 32'(k), {26'd0, VEC[k][5:0]}, 1'b1);
        end

        // R9: flags without a valid commit, then valid commit with no flags
        apply(1'b0, 10'h3FF, 2'd3, 1'b1, 32'hAAAA_0000, 32'h1111_1111, 32'h2222_2222, 32'd0, 1'b0);
        apply(1'b1, 10'h000, 2'd1, 1'b0, 32'hBBBB_0000, 32'h3333_3333, 32'h4444_4444, 32'd0, 1'b0);

        // R6 corner: fetch and data flags together, distinct addresses
        apply(1'b1, 10'h302, 2'd0, 1'b1, 32'h0000_2000, 32'h5555_5550, 32'h6666_6660, 32'd1, 1'b1);
        apply(1'b1, 10'h204, 2'd0, 1'b1, 32'h0000_2004, 32'h5555_5554, 32'h6666_6664, 32'd2, 1'b1);

        // Back-to-back traps
        apply(1'b1, 10'h100, 2'd1, 1'b0, 32'h0000_3000, 32'h7777_0000, 32'h8888_0000, 32'd13, 1'b1);
        apply(1'b1, 10'h008, 2'd1, 1'b0, 32'h0000_3004, 32'h7777_0004, 32'h8888_0004, 32'd0, 1'b1);

        // Random combinations against the reference priority function
        for (int r = 0; r < 400; r++) begin
            logic [9:0] rf;
            rf = 10'($urandom) & 10'($urandom);
            apply(($urandom % 8) != 0, rf, 2'($urandom), 1'($urandom),
                  $urandom, $urandom | 32'h1, $urandom & ~32'h1, 32'd0, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule